// File: doc/BRIEF.md
# Early-Terminating Booth Multiplier

This block is a sequential multiplier for a processor's integer datapath. It takes two operand words, a multiplicand and a multiplier. It returns the low word of their product, optionally with a third operand added in. The multiplier is recoded two bits at a time into signed digits in the set {-2, -1, 0, +1, +2}. Each cycle adds one shifted multiple of the multiplicand to a running sum. Because only the low word is kept, the result is the same whether the operands are taken as signed or unsigned.

The latency depends on the data. After one set-up cycle, each bit pair of the multiplier costs one cycle. The scan stops once the bits still waiting are all zero and the last bit scanned was zero, because every remaining digit would then be zero. A small multiplier finishes in a few cycles. A negative multiplier has ones in its upper bits, so it runs the full length. A request is accepted on a start pulse while the block is idle. The block then reports busy, and it finishes with a single-cycle done strobe. When a request asks for it, the block also updates a sign flag and a zero flag from the result.

Top module: `booth_mul`

## Requirements
- R1: While reset is low, and right after it, busy, done, result, flag_n and flag_z are all 0.
- R2: result equals the low WIDTH bits of mcand times mplier. The operands count as signed or as unsigned alike, because only the low word is kept.
- R3: When acc_en is 1 at acceptance, addend is added to the product. When acc_en is 0, addend has no effect on the result.
- R4: Let P be the smallest k in 0..WIDTH/2-1 for which mplier shifted right by 2k is zero and bit 2k-1 of mplier is 0 (take that bit as 0 for k = 0); if no such k exists, P = WIDTH/2. done is then high exactly P+1 clock edges after the edge that accepts start.
- R5: With the default width, a multiplier of 18 takes 4 cycles, a multiplier of all ones takes 17 cycles, and a multiplier of 0 takes 1 cycle.
- R6: done is high for exactly one cycle. result changes only in the cycle where done is high, and it then holds until the next done.
- R7: start is accepted only while busy is 0. A start pulse or operand change while busy is 1 has no effect on the result, on the flags or on the number of done pulses.
- R8: If set_flags is 1 at acceptance, then when done is high flag_n equals result bit WIDTH-1 and flag_z is 1 exactly when result is zero. If set_flags is 0, both flags keep their previous values.
- R9: busy is 1 from the edge that accepts start until the edge that raises done. When done is high, busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request; accepted on a rising edge when busy is 0 |
| acc_en | input | 1 | Add addend to the product, sampled at acceptance |
| set_flags | input | 1 | Update flag_n and flag_z at completion, sampled at acceptance |
| mcand | input | WIDTH | Multiplicand, sampled at acceptance |
| mplier | input | WIDTH | Multiplier that is recoded and scanned, sampled at acceptance |
| addend | input | WIDTH | Accumulate operand, sampled at acceptance |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | WIDTH | Low word of product plus optional addend, held between completions |
| flag_n | output | 1 | Sign of the last flag-setting result |
| flag_z | output | 1 | Zero indication of the last flag-setting result |

## Verification
The checker assumes that every input is sampled only at the acceptance edge, and that set_flags keeps the meaning it had at that edge until done. Its flag and latency properties depend on this. The stimulus changes the inputs only on falling edges and then waits for busy to drop before it issues the next real request. On purpose, it also asserts start with unrelated operands in the middle of a long operation. That run shows that such pulses are ignored and do not break the one-request, one-strobe pairing the properties rely on.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

    // One radix-4 recoded digit: magnitude select plus sign.
    typedef struct packed {
        logic neg;   // subtract the selected multiple
        logic one;   // magnitude 1
        logic two;   // magnitude 2
    } digit_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_mul_pkg::*;
(
    input  logic [2:0] trip,   // {bit 2k+1, bit 2k, bit 2k-1}
    output digit_t     dig
);

    always_comb begin
        dig = '0;
        unique case (trip)
            3'b001, 3'b010: dig.one = 1'b1;
            3'b011:         dig.two = 1'b1;
            3'b100: begin
                dig.two = 1'b1;
                dig.neg = 1'b1;
            end
            3'b101, 3'b110: begin
                dig.one = 1'b1;
                dig.neg = 1'b1;
            end
            default:        dig = '0;
        endcase
    end

endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mc,
    input  digit_t           dig,
    output logic [WIDTH-1:0] pp
);

    logic [WIDTH-1:0] mag;

    always_comb begin
        if (dig.two)      mag = mc << 1;
        else if (dig.one) mag = mc;
        else              mag = '0;
        pp = dig.neg ? (~mag + 1'b1) : mag;
    end

endmodule

// File: rtl/booth_term.sv
module booth_term #(
    parameter int WIDTH = 32,
    parameter int PAIRS = WIDTH / 2,
    parameter int CNT_W = 5
) (
    input  logic [WIDTH-1:0] mpl,
    input  logic             prev,
    input  logic [CNT_W-1:0] cnt,
    output logic             fin
);

    // All remaining digits are zero once the unscanned bits and the
    // last scanned bit are all zero; otherwise stop after every pair.
    always_comb begin
        fin = (cnt == CNT_W'(PAIRS)) || ((mpl == '0) && !prev);
    end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
    import booth_mul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             acc_en,
    input  logic             set_flags,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    input  logic [WIDTH-1:0] addend,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z
);

    localparam int PAIRS = WIDTH / 2;
    localparam int CNT_W = $clog2(PAIRS + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             sf;
        logic             prev;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] mc;
        logic [WIDTH-1:0] mpl;
        logic [WIDTH-1:0] res;
        logic             fn;
        logic             fz;
    } state_t;

    state_t           s_d, s_q;
    digit_t           dig;
    logic [WIDTH-1:0] pp;
    logic             fin;

    booth_recoder u_rec (
        .trip ({s_q.mpl[1:0], s_q.prev}),
        .dig  (dig)
    );

    booth_ppgen #(.WIDTH(WIDTH)) u_pp (
        .mc  (s_q.mc),
        .dig (dig),
        .pp  (pp)
    );

    booth_term #(.WIDTH(WIDTH), .PAIRS(PAIRS), .CNT_W(CNT_W)) u_term (
        .mpl  (s_q.mpl),
        .prev (s_q.prev),
        .cnt  (s_q.cnt),
        .fin  (fin)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.sf   = set_flags;
                s_d.acc  = acc_en ? addend : '0;
                s_d.mc   = mcand;
                s_d.mpl  = mplier;
                s_d.prev = 1'b0;
                s_d.cnt  = '0;
            end
        end else if (fin) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.res  = s_q.acc;
            if (s_q.sf) begin
                s_d.fn = s_q.acc[WIDTH-1];
                s_d.fz = (s_q.acc == '0);
            end
        end else begin
            s_d.acc  = s_q.acc + pp;
            s_d.mc   = s_q.mc << 2;
            s_d.mpl  = s_q.mpl >> 2;
            s_d.prev = s_q.mpl[1];
            s_d.cnt  = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign result = s_q.res;
    assign flag_n = s_q.fn;
    assign flag_z = s_q.fz;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             set_flags,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z
);

    localparam int PAIRS = WIDTH / 2;
    localparam int LAT_W = $clog2(PAIRS + 3);

    logic [LAT_W-1:0] lat;
    logic             sf_l;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat  <= '0;
            sf_l <= 1'b0;
        end else if (start && !busy) begin
            lat  <= '0;
            sf_l <= set_flags;
        end else if (busy && (lat != '1)) begin
            lat  <= lat + 1'b1;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                              // R6
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));                                   // R6
    AST_LATENCY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat >= LAT_W'(1)) && (lat <= LAT_W'(PAIRS + 1)));   // R4
    AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sf_l) |-> (flag_n == result[WIDTH-1]));              // R8
    AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sf_l) |-> (flag_z == (result == '0)));               // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || !sf_l) |-> ($stable(flag_n) && $stable(flag_z)));   // R8
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);                                              // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));                                        // R9

endmodule

bind booth_mul booth_mul_chk #(.WIDTH(WIDTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .set_flags (set_flags),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .flag_n    (flag_n),
    .flag_z    (flag_z)
);

// File: tb/test_booth_mul.sv
module test_booth_mul;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        acc_en = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] mcand = '0;
    logic [31:0] mplier = '0;
    logic [31:0] addend = '0;
    logic        busy, done, flag_n, flag_z;
    logic [31:0] result;

    booth_mul #(.WIDTH(32)) i_booth_mul (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_en(acc_en),
        .set_flags(set_flags), .mcand(mcand), .mplier(mplier),
        .addend(addend), .busy(busy), .done(done), .result(result),
        .flag_n(flag_n), .flag_z(flag_z)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [31:0] res;
        int          lat;
        bit          n;
        bit          z;
        longint      t0;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          tests = 0;
    int          fails = 0;
    longint      cyc = 0;
    bit          fn_m = 0, fz_m = 0;
    bit          prev_done = 0;
    logic [31:0] last_res = '0;
    bit          finished = 0;
    logic [31:0] seed = 32'h1234_5678;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_pairs(input logic [31:0] m);
        for (int k = 0; k < 16; k++) begin
            if (((m >> (2 * k)) == 32'd0) && (k == 0 || m[2 * k - 1] == 1'b0))
                return k;
        end
        return 16;
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input bit ae, input bit sf,
                          input string tag);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        mcand = a; mplier = b; addend = c; acc_en = ae; set_flags = sf;
        start = 1'b1;
        it.res = a * b + (ae ? c : 32'd0);
        it.lat = exp_pairs(b) + 1;
        if (sf) begin
            fn_m = it.res[31];
            fz_m = (it.res == 32'd0);
        end
        it.n = fn_m; it.z = fz_m; it.t0 = cyc; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    endtask

    // Monitor: pops one expected item per done strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                chk(done == 1'b0, "R6 done width", 64'(done), 64'd0);
                chk(result == last_res, "R6 result hold", 64'(result), 64'(last_res));
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 64'd1, 64'd0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(result == it.res, {"R2/R3 result ", it.tag}, 64'(result), 64'(it.res));
                    chk(int'(cyc - it.t0 - 1) == it.lat, {"R4 latency ", it.tag},
                        64'(cyc - it.t0 - 1), 64'(it.lat));
                    chk(flag_n == it.n, {"R8 flag_n ", it.tag}, 64'(flag_n), 64'(it.n));
                    chk(flag_z == it.z, {"R8 flag_z ", it.tag}, 64'(flag_z), 64'(it.z));
                    chk(busy == 1'b0, "R9 idle at done", 64'(busy), 64'd0);
                end
            end
            prev_done = done;
            last_res  = result;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, done, flag_n, flag_z} == 4'b0 && result == 32'd0, "R1 reset state",
            64'({busy, done, flag_n, flag_z, result}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done} == 2'b0, "R1 after release", 64'({busy, done}), 64'd0);

        run_op(32'd7, 32'd18, 32'd0, 0, 0, "R5 m18");
        run_op(32'd5, 32'hFFFF_FFFF, 32'd0, 0, 1, "R5 mall1");
        run_op(32'h1234, 32'd0, 32'd0, 0, 1, "R5 m0 zero");
        run_op(32'hFFFF_FFFD, 32'd7, 32'd100, 1, 1, "R3 acc");
        run_op(32'h0001_0000, 32'h0001_0000, 32'd0, 0, 1, "R2 wrap");
        run_op(32'd3, 32'h8000_0000, 32'd0, 0, 0, "R8 keep flags");
        run_op(32'd1, 32'd1, 32'd0, 0, 1, "R4 m1");
        run_op(32'd2, 32'd2, 32'd0, 0, 1, "R4 m2");
        run_op(32'hFFFF_FFF9, 32'hFFFF_FFF7, 32'd0, 0, 1, "R2 signed");
        run_op(32'd9, 32'd9, 32'hDEAD_BEEF, 0, 1, "R3 addend off");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 1, 1, "R2 max");

        // R7: disturb a long operation with extra start pulses.
        run_op(32'd11, 32'hFFFF_FFF0, 32'd0, 0, 1, "R7 base");
        repeat (3) begin
            mcand = 32'h5555_5555; mplier = 32'd3; addend = 32'd77;
            acc_en = 1'b1; set_flags = 1'b1; start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        run_op(32'd4, 32'd4, 32'd0, 0, 0, "R7 follow");

        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b, c;
            seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
            seed = seed * 32'd1664525 + 32'd1013904223; b = seed >> seed[4:0];
            seed = seed * 32'd1664525 + 32'd1013904223; c = seed;
            run_op(a, b, c, c[0], c[1], "R2 sweep");
        end

        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R7 all items drained", 64'(sb.size()), 64'd0);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule